// File: doc/BRIEF.md
# Grayscale Display Period Controller

This block sets the timing of a PWM display period for a multi-channel LED sink driver. It keeps a grayscale counter that moves forward once for each accepted grayscale reference clock edge, and it raises an outputs-enabled flag while the downstream pulse-width comparators may drive their channels. The comparison of the counter against per-channel grayscale values is done outside this block.

The reference is either a free-running internal oscillator or the serial shift clock. Both are brought into the system clock domain through synchronisers. A control bit chooses whether the rising or the falling reference edge is counted. The period runs once and then halts, or it repeats back to back. A blank control forces the counter to zero and turns the outputs off. A latch pulse can restart the period when timing reset is enabled. An over-temperature input turns the outputs off, and they come back only at the start of the next period.

Top module: `gs_period_timer`

## Requirements
- R1: Each accepted reference edge, other than the first one after a start event, adds one to `gsCount`. The count climbs from 0 up to 2^CNT_W-1. The count does not change when no edge is accepted.
- R2: One cycle after `blankBit` is 1, `gsCount` is 0 and `outEnable` is 0. Both stay at those values while blank is held, whatever the reference clocks do.
- R3: When `extClkSel` is 1, only `shiftClk` edges count. When it is 0, only `intOscClk` edges count.
- R4: When `riseEdgeSel` is 1, the 0-to-1 transition of the selected reference is counted. When it is 0, the 1-to-0 transition is counted. The opposite transition has no effect.
- R5: A start event is either `blankBit` falling to 0, or a `latchPulse` with `tmgRstBit` at 1 while not blanked. After a start event, `outEnable` stays 0 and `gsCount` stays 0 until the first reference edge. That edge sets `outEnable` to 1 and leaves the count at 0.
- R6: `countStrobe` is a single-cycle pulse for each accepted edge. Its high cycle is the first cycle in which `gsCount` shows the value for the new slot.
- R7: When `repeatBit` is 0, an edge that arrives while the count is 2^CNT_W-1 ends the period. `outEnable` drops to 0 and the count holds at 2^CNT_W-1. Later edges are ignored until the next start event.
- R8: When `repeatBit` is 1, the edge at count 2^CNT_W-1 wraps the count to 0. `outEnable` stays at 1 through the wrap.
- R9: A `latchPulse` with `tmgRstBit` at 1 clears `gsCount` to 0 and turns the outputs off. The restart then follows R5.
- R10: A `latchPulse` with `tmgRstBit` at 0 changes neither `gsCount` nor `outEnable`.
- R11: One cycle after `overTemp` is 1, `outEnable` is 0. After `overTemp` clears, the outputs stay off for the rest of the period while the count keeps advancing. They turn back on at the wrap to count 0 or at a start event.
- R12: After reset with blank held, `gsCount` is 0 and `outEnable` and `countStrobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blankBit | input | 1 | Blank control from the data latch |
| repeatBit | input | 1 | Selects auto-repeat (1) or one-shot (0) period |
| tmgRstBit | input | 1 | Lets a latch pulse restart the period |
| extClkSel | input | 1 | Selects shift clock (1) or internal oscillator (0) as reference |
| riseEdgeSel | input | 1 | Counts the rising (1) or falling (0) reference edge |
| latchPulse | input | 1 | Single-cycle internal latch pulse |
| intOscClk | input | 1 | Internal oscillator reference, asynchronous |
| shiftClk | input | 1 | Serial shift clock reference, asynchronous |
| overTemp | input | 1 | Over-temperature flag |
| gsCount | output | CNT_W | Grayscale counter value |
| countStrobe | output | 1 | Pulse for each accepted reference edge |
| outEnable | output | 1 | Outputs may be driven |

## Verification
The bench builds the block with CNT_W set to 4, which gives a 16-slot period, and with the default two-stage synchroniser. With this setting, the one-shot end at count 15, the repeat wrap back to 0, and the over-temperature recovery at a period boundary can each be reached in a few dozen reference pulses. Each reference pulse lasts longer than the synchroniser and edge-detect latency, so every effect has settled before the next check.

// File: rtl/gs_period_pkg.sv
package gs_period_pkg;
  typedef struct packed {
    logic clear;    // force counter to zero
    logic advance;  // add one to the counter
    logic tick;     // an edge was accepted (new slot)
  } gsStrobes_t;
endpackage

// File: rtl/gs_period_count.sv
module gs_period_count
  import gs_period_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  gsStrobes_t       strobes,
  output logic [CNT_W-1:0] count,
  output logic             isTerminal,
  output logic             slotStrobe
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      slotStrobe <= 1'b0;
    end else begin
      if (strobes.clear)        count <= '0;
      else if (strobes.advance) count <= count + 1'b1;
      slotStrobe <= strobes.tick & ~strobes.clear;
    end
  end

  assign isTerminal = (count == LAST);

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (count == '0));
  p_step_one_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.clear) |=> (count == CNT_W'($past(count) + 1'b1)));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.advance || strobes.clear) |=> $stable(count));
endmodule

// File: rtl/gs_period_ctrl.sv
module gs_period_ctrl
  import gs_period_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       blankBit,
  input  logic       repeatBit,
  input  logic       tmgRstBit,
  input  logic       extClkSel,
  input  logic       riseEdgeSel,
  input  logic       latchPulse,
  input  logic       intOscClk,
  input  logic       shiftClk,
  input  logic       overTemp,
  input  logic       isTerminal,
  output gsStrobes_t strobes,
  output logic       outEnable
);
  localparam int NUM_REF = 2;

  logic [NUM_REF-1:0] rawRef;
  logic [NUM_REF-1:0] refSynced;
  assign rawRef = {shiftClk, intOscClk};

  for (genvar g = 0; g < NUM_REF; g++) begin : gen_sync
    logic [SYNC_STAGES-1:0] stages;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stages <= '0;
      else       stages <= {stages[SYNC_STAGES-2:0], rawRef[g]};
    end
    assign refSynced[g] = stages[SYNC_STAGES-1];
  end

  logic refCur, refPrev, refEdge;
  logic blankPrev, active, waitFirst, otHold;
  logic startEv, acceptEdge, wrapEv, endEv;

  assign refCur  = extClkSel ? refSynced[1] : refSynced[0];
  assign refEdge = riseEdgeSel ? (refCur & ~refPrev) : (~refCur & refPrev);

  assign startEv    = !blankBit && (blankPrev || (latchPulse && tmgRstBit));
  assign acceptEdge = active && refEdge && !blankBit && !startEv &&
                      (waitFirst || !isTerminal || repeatBit);
  assign endEv      = active && refEdge && !blankBit && !startEv &&
                      !waitFirst && isTerminal && !repeatBit;

  always_comb begin
    strobes.clear   = blankBit | startEv;
    strobes.tick    = acceptEdge;
    strobes.advance = acceptEdge & ~waitFirst;
  end
  assign wrapEv = strobes.advance & isTerminal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev   <= 1'b0;
      blankPrev <= 1'b1;
      active    <= 1'b0;
      waitFirst <= 1'b0;
      otHold    <= 1'b0;
    end else begin
      refPrev   <= refCur;
      blankPrev <= blankBit;
      if (blankBit) begin
        active    <= 1'b0;
        waitFirst <= 1'b0;
      end else if (startEv) begin
        active    <= 1'b1;
        waitFirst <= 1'b1;
      end else if (acceptEdge && waitFirst) begin
        waitFirst <= 1'b0;
      end else if (endEv) begin
        active    <= 1'b0;
      end
      if (overTemp)                          otHold <= 1'b1;
      else if (otHold && (wrapEv || startEv)) otHold <= 1'b0;
    end
  end

  assign outEnable = active & ~waitFirst & ~otHold;

  p_blank_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    blankBit |=> !outEnable);
  p_ot_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    overTemp |=> !outEnable);
  p_start_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !outEnable);
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    endEv |=> (!outEnable && !active));
  p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |-> strobes.tick);
endmodule

// File: rtl/gs_period_timer.sv
module gs_period_timer
  import gs_period_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blankBit,
  input  logic             repeatBit,
  input  logic             tmgRstBit,
  input  logic             extClkSel,
  input  logic             riseEdgeSel,
  input  logic             latchPulse,
  input  logic             intOscClk,
  input  logic             shiftClk,
  input  logic             overTemp,
  output logic [CNT_W-1:0] gsCount,
  output logic             countStrobe,
  output logic             outEnable
);
  gsStrobes_t strobes;
  logic       isTerminal;

  gs_period_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .blankBit(blankBit), .repeatBit(repeatBit),
    .tmgRstBit(tmgRstBit), .extClkSel(extClkSel), .riseEdgeSel(riseEdgeSel),
    .latchPulse(latchPulse), .intOscClk(intOscClk), .shiftClk(shiftClk),
    .overTemp(overTemp), .isTerminal(isTerminal), .strobes(strobes),
    .outEnable(outEnable)
  );

  gs_period_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .strobes(strobes), .count(gsCount),
    .isTerminal(isTerminal), .slotStrobe(countStrobe)
  );

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    countStrobe |=> !countStrobe);
endmodule

// File: tb/tb_gs_period_timer.sv
`timescale 1ns/1ps
module tb_gs_period_timer;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blankBit = 1'b1, repeatBit = 1'b0, tmgRstBit = 1'b0;
  logic extClkSel = 1'b0, riseEdgeSel = 1'b1, latchPulse = 1'b0;
  logic intOscClk = 1'b0, shiftClk = 1'b0, overTemp = 1'b0;
  logic [W-1:0] gsCount;
  logic countStrobe, outEnable;

  int compared = 0;
  int mismatched = 0;
  int stbCount = 0;

  always #5 clk = ~clk;

  gs_period_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .blankBit(blankBit), .repeatBit(repeatBit),
    .tmgRstBit(tmgRstBit), .extClkSel(extClkSel), .riseEdgeSel(riseEdgeSel),
    .latchPulse(latchPulse), .intOscClk(intOscClk), .shiftClk(shiftClk),
    .overTemp(overTemp), .gsCount(gsCount), .countStrobe(countStrobe),
    .outEnable(outEnable)
  );

  always @(negedge clk) if (rstN && countStrobe) stbCount++;

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int expCnt, input bit expEn);
    compared++;
    if (gsCount !== W'(expCnt) || outEnable !== expEn) begin
      mismatched++;
      $display("FAIL %s: count=%0d en=%0b expected count=%0d en=%0b",
               tag, gsCount, outEnable, expCnt, expEn);
    end
  endtask

  task automatic chkStb(input string tag, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: strobes=%0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic pulse(input bit useShift, input int n);
    for (int i = 0; i < n; i++) begin
      if (useShift) shiftClk = 1'b1; else intOscClk = 1'b1;
      waitCyc(4);
      if (useShift) shiftClk = 1'b0; else intOscClk = 1'b0;
      waitCyc(4);
    end
  endtask

  task automatic tReset();
    chk("R12 reset state", 0, 1'b0);
    chkStb("R12 no strobe", stbCount, 0);
  endtask

  task automatic tBlankHold();
    pulse(1'b0, 3);
    chk("R2 blank holds zero", 0, 1'b0);
  endtask

  task automatic tOneShot();
    int s0;
    blankBit = 1'b0;
    waitCyc(3);
    chk("R5 off before first edge", 0, 1'b0);
    s0 = stbCount;
    pulse(1'b0, 1);
    chk("R5 first edge enables at 0", 0, 1'b1);
    chkStb("R6 strobe on first edge", stbCount - s0, 1);
    s0 = stbCount;
    pulse(1'b0, 5);
    chk("R1 five steps", 5, 1'b1);
    chkStb("R6 one strobe per edge", stbCount - s0, 5);
    pulse(1'b0, 10);
    chk("R1 reaches top", 15, 1'b1);
    s0 = stbCount;
    pulse(1'b0, 1);
    chk("R7 one-shot ends", 15, 1'b0);
    pulse(1'b0, 2);
    chk("R7 halted ignores edges", 15, 1'b0);
    chkStb("R7 no strobes after end", stbCount - s0, 0);
  endtask

  task automatic tRepeat();
    blankBit = 1'b1;
    waitCyc(2);
    chk("R2 blank clears", 0, 1'b0);
    repeatBit = 1'b1;
    blankBit = 1'b0;
    pulse(1'b0, 1);
    chk("R5 restart after blank", 0, 1'b1);
    pulse(1'b0, 15);
    chk("R8 top in repeat", 15, 1'b1);
    pulse(1'b0, 1);
    chk("R8 wraps to zero", 0, 1'b1);
    pulse(1'b0, 3);
    chk("R8 continues", 3, 1'b1);
  endtask

  task automatic tClockSel();
    extClkSel = 1'b1;
    waitCyc(4);
    pulse(1'b0, 1);
    chk("R3 oscillator ignored", 3, 1'b1);
    pulse(1'b1, 1);
    chk("R3 shift clock counts", 4, 1'b1);
  endtask

  task automatic tEdgeSel();
    riseEdgeSel = 1'b0;
    waitCyc(2);
    shiftClk = 1'b1; waitCyc(4);
    chk("R4 rise ignored in fall mode", 4, 1'b1);
    shiftClk = 1'b0; waitCyc(4);
    chk("R4 fall counted", 5, 1'b1);
    riseEdgeSel = 1'b1;
    waitCyc(2);
    shiftClk = 1'b1; waitCyc(4);
    chk("R4 rise counted", 6, 1'b1);
    shiftClk = 1'b0; waitCyc(4);
    chk("R4 fall ignored in rise mode", 6, 1'b1);
  endtask

  task automatic tLatch();
    tmgRstBit = 1'b0;
    latchPulse = 1'b1; waitCyc(1); latchPulse = 1'b0;
    waitCyc(3);
    chk("R10 latch without reset", 6, 1'b1);
    tmgRstBit = 1'b1;
    latchPulse = 1'b1; waitCyc(1); latchPulse = 1'b0;
    waitCyc(3);
    chk("R9 latch reset clears", 0, 1'b0);
    pulse(1'b1, 1);
    chk("R9 resumes on first edge", 0, 1'b1);
    pulse(1'b1, 2);
    chk("R9 counts after restart", 2, 1'b1);
  endtask

  task automatic tOverTemp();
    overTemp = 1'b1; waitCyc(3);
    chk("R11 off under over-temperature", 2, 1'b0);
    overTemp = 1'b0;
    pulse(1'b1, 3);
    chk("R11 stays off mid-period", 5, 1'b0);
    pulse(1'b1, 10);
    chk("R11 stays off at top", 15, 1'b0);
    pulse(1'b1, 1);
    chk("R11 resumes at boundary", 0, 1'b1);
  endtask

  task automatic tBlankMid();
    pulse(1'b1, 4);
    chk("R1 counts before blank", 4, 1'b1);
    blankBit = 1'b1; waitCyc(2);
    chk("R2 blank mid-run", 0, 1'b0);
    pulse(1'b1, 2);
    chk("R2 edges ignored while blank", 0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    tReset();
    tBlankHold();
    tOneShot();
    tRepeat();
    tClockSel();
    tEdgeSel();
    tLatch();
    tOverTemp();
    tBlankMid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule